// File: doc/BRIEF.md
# Combinatorial Linear Track Fitter

This block fits straight-line-in-parameter-space track candidates from the clusters of a single road. A road is loaded as a list of cluster coordinates per detector layer. After the go pulse the block walks through every choice that takes exactly one cluster from each layer. For each choice it forms a set of fixed-point dot products between the coordinate vector and preloaded coefficient rows. The first rows give the track parameters and the remaining rows give residual terms. The squares of the residual terms are summed into a chi-square, and the choice is reported only when that sum lies under a programmable cut.

A road in which exactly one layer has no cluster is still fitted. The block then uses a separate coefficient set kept for that missing layer, and the empty coordinate counts as zero. The layer count, per-layer cluster capacity, parameter and residual row counts and the fixed-point scaling are all parameters, so the same formula serves a narrow first-pass fit or a wider refit. Coefficients are written one word at a time through a configuration port.

Top module: `lfit_track_fitter`

## Requirements
- R1: After synchronous reset, `busy`, `trk_valid` and `rd_done` are 0.
- R2: Each one-cluster-per-layer combination of a road appears at most once. The records come out in odometer order, with layer NLAYERS-1 stepping fastest and layer 0 slowest. The cluster index chosen for layer l sits at `trk_idx[l*IDXW +: IDXW]`, and clusters of a layer are numbered 0 upward in arrival order.
- R3: Parameter j, at `trk_par[j*16 +: 16]`, is bits [FRAC+15:FRAC] of the full-precision sum over layers l of coef(s,j,l)*x_l. Here s is `trk_hole`, and coef(s,row,l) is the signed 16-bit word written at configuration address (s*NROW+row)*NLAYERS+l, with NROW = NPAR+NRES.
- R4: `trk_chi2` is the unsigned sum of squares of residual rows NPAR..NROW-1. Each residual row is formed and truncated exactly as in R3.
- R5: A combination gives a record only if its chi-square is strictly less than `chi_cut`.
- R6: If exactly one layer L has no cluster, the road is still fitted. Coefficient set L+1 is used, x_L counts as 0, `trk_hole` = L+1 and the index field of layer L is 0. A road with no empty layer uses set 0 and `trk_hole` = 0.
- R7: A road with two or more empty layers produces no record, but still ends with `rd_done`.
- R8: A layer keeps at most MAXCL clusters, and later clusters for it are dropped. If any cluster of the road was dropped, `trk_ovf` is 1 on all of that road's records; otherwise it is 0.
- R9: `trk_road` equals the `rd_id` captured with the `rd_open` pulse of the road the record belongs to.
- R10: Each accepted `rd_go` leads to exactly one single-cycle `rd_done` pulse. `busy` drops to 0 in that same cycle, and no record follows it before the next road is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | CAW | Coefficient address (set*NROW+row)*NLAYERS+layer |
| cfg_data | input | 16 | Signed coefficient word |
| chi_cut | input | CHIW | Chi-square acceptance limit (strict) |
| rd_open | input | 1 | Begin loading a new road (ignored while busy) |
| rd_id | input | IDW | Road identifier captured on rd_open |
| hit_valid | input | 1 | Cluster coordinate strobe (ignored while busy) |
| hit_layer | input | LW | Layer of the cluster |
| hit_coord | input | 16 | Signed cluster coordinate |
| rd_go | input | 1 | Start fitting the loaded road (ignored while busy) |
| busy | output | 1 | Road fit in progress |
| trk_valid | output | 1 | Accepted track record present |
| trk_road | output | IDW | Road identifier of the record |
| trk_hole | output | HW | 0, or missing layer + 1 |
| trk_idx | output | NLAYERS*IDXW | Chosen cluster index per layer |
| trk_par | output | NPAR*16 | Track parameters |
| trk_chi2 | output | CHIW | Chi-square of the record |
| trk_ovf | output | 1 | Road lost clusters to the per-layer cap |
| rd_done | output | 1 | Road fully processed |

## Verification
Roads with one cluster in every layer isolate the arithmetic of a single fit. Uneven counts per layer expose any error in the odometer order or in the count of combinations. Full roads under a middling cut check that filtering keeps the right subset, in order, and a cut equal to a known chi-square and then one above it separates a strict comparison from a non-strict one. Roads with one empty layer in different places show that the matching coefficient set is selected. Roads with two empty layers, an over-full layer and a zero cut cover the paths that produce no records or flagged records.

// File: rtl/lfit_pkg.sv
package lfit_pkg;

    localparam int CW = 16;

    typedef enum logic {EN_IDLE, EN_RUN} en_state_e;

    // Arithmetic right shift of a wide accumulator, keeping CW bits.
    function automatic logic [CW-1:0] scale_q(input logic signed [63:0] a,
                                              input int unsigned frac);
        logic signed [63:0] s;
        s = a >>> frac;
        return s[CW-1:0];
    endfunction

endpackage

// File: rtl/lfit_hit_store.sv
module lfit_hit_store import lfit_pkg::*; #(
    parameter int NLAYERS = 4,
    parameter int MAXCL   = 4,
    parameter int IDW     = 8,
    localparam int LW     = $clog2(NLAYERS),
    localparam int IDXW   = $clog2(MAXCL),
    localparam int CNTW   = $clog2(MAXCL + 1),
    localparam int HW     = $clog2(NLAYERS + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             open_i,
    input  logic [IDW-1:0]                   open_id_i,
    input  logic                             wr_i,
    input  logic [LW-1:0]                    wr_layer_i,
    input  logic [CW-1:0]                    wr_coord_i,
    input  logic [NLAYERS-1:0][IDXW-1:0]     rd_idx_i,
    input  logic [HW-1:0]                    rd_hole_i,
    output logic [NLAYERS-1:0][CNTW-1:0]     cnt_o,
    output logic [NLAYERS-1:0][CW-1:0]       x_o,
    output logic [IDW-1:0]                   road_o,
    output logic                             ovf_o
);

    logic [CW-1:0]   mem   [NLAYERS][MAXCL];
    logic [CNTW-1:0] cnt_q [NLAYERS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NLAYERS; l++) cnt_q[l] <= '0;
            ovf_o  <= 1'b0;
            road_o <= '0;
        end else if (open_i) begin
            for (int l = 0; l < NLAYERS; l++) cnt_q[l] <= '0;
            ovf_o  <= 1'b0;
            road_o <= open_id_i;
        end else if (wr_i && int'(wr_layer_i) < NLAYERS) begin
            if (cnt_q[wr_layer_i] == CNTW'(MAXCL)) begin
                ovf_o <= 1'b1;
            end else begin
                mem[wr_layer_i][cnt_q[wr_layer_i][IDXW-1:0]] <= wr_coord_i;
                cnt_q[wr_layer_i] <= cnt_q[wr_layer_i] + CNTW'(1);
            end
        end
    end

    always_comb begin
        for (int l = 0; l < NLAYERS; l++) begin
            cnt_o[l] = cnt_q[l];
            x_o[l]   = (rd_hole_i == HW'(l + 1)) ? '0 : mem[l][rd_idx_i[l]];
        end
    end

endmodule

// File: rtl/lfit_combo_enum.sv
module lfit_combo_enum import lfit_pkg::*; #(
    parameter int NLAYERS = 4,
    parameter int MAXCL   = 4,
    localparam int IDXW   = $clog2(MAXCL),
    localparam int CNTW   = $clog2(MAXCL + 1),
    localparam int HW     = $clog2(NLAYERS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [NLAYERS-1:0][CNTW-1:0] cnt_i,
    output logic                         vld_o,
    output logic                         last_o,
    output logic [NLAYERS-1:0][IDXW-1:0] idx_o,
    output logic [HW-1:0]                hole_o
);

    en_state_e                    st;
    logic [NLAYERS-1:0][IDXW-1:0] idx_q, idx_nx;
    logic [HW-1:0]                hole_q, hole_calc;
    int unsigned                  n_empty;
    logic                         at_end;

    // Empty-layer census taken when a road is started.
    always_comb begin
        n_empty   = 0;
        hole_calc = '0;
        for (int l = 0; l < NLAYERS; l++) begin
            if (cnt_i[l] == '0) begin
                n_empty   = n_empty + 1;
                hole_calc = HW'(l + 1);
            end
        end
    end

    // Odometer step: last layer is the least significant digit.
    always_comb begin
        logic             carry;
        logic             top;
        logic [CNTW-1:0]  lim;
        carry  = 1'b1;
        at_end = 1'b1;
        idx_nx = idx_q;
        for (int l = NLAYERS - 1; l >= 0; l--) begin
            lim = (hole_q == HW'(l + 1)) ? CNTW'(1) : cnt_i[l];
            top = (CNTW'(idx_q[l]) == lim - CNTW'(1));
            if (!top) at_end = 1'b0;
            if (carry) begin
                if (top) begin
                    idx_nx[l] = '0;
                end else begin
                    idx_nx[l] = idx_q[l] + IDXW'(1);
                    carry     = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EN_IDLE;
            idx_q  <= '0;
            hole_q <= '0;
            vld_o  <= 1'b0;
            last_o <= 1'b0;
            idx_o  <= '0;
            hole_o <= '0;
        end else begin
            vld_o  <= 1'b0;
            last_o <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (start_i) begin
                        if (n_empty > 1) begin
                            last_o <= 1'b1;
                        end else begin
                            st     <= EN_RUN;
                            idx_q  <= '0;
                            hole_q <= hole_calc;
                        end
                    end
                end
                EN_RUN: begin
                    vld_o  <= 1'b1;
                    last_o <= at_end;
                    idx_o  <= idx_q;
                    hole_o <= hole_q;
                    if (at_end) st <= EN_IDLE;
                    else        idx_q <= idx_nx;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lfit_dot_stage.sv
module lfit_dot_stage import lfit_pkg::*; #(
    parameter int NLAYERS = 4,
    parameter int MAXCL   = 4,
    parameter int NPAR    = 2,
    parameter int NRES    = 2,
    parameter int FRAC    = 8,
    localparam int IDXW   = $clog2(MAXCL),
    localparam int HW     = $clog2(NLAYERS + 1),
    localparam int NROW   = NPAR + NRES,
    localparam int NSET   = NLAYERS + 1,
    localparam int NCOEF  = NSET * NROW * NLAYERS,
    localparam int CAW    = $clog2(NCOEF),
    localparam int ACCW   = 2 * CW + $clog2(NLAYERS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we_i,
    input  logic [CAW-1:0]               cfg_addr_i,
    input  logic [CW-1:0]                cfg_data_i,
    input  logic                         vld_i,
    input  logic                         last_i,
    input  logic [NLAYERS-1:0][IDXW-1:0] idx_i,
    input  logic [HW-1:0]                hole_i,
    input  logic [NLAYERS-1:0][CW-1:0]   x_i,
    output logic                         vld_o,
    output logic                         last_o,
    output logic [NLAYERS-1:0][IDXW-1:0] idx_o,
    output logic [HW-1:0]                hole_o,
    output logic [NROW-1:0][CW-1:0]      rows_o
);

    logic [CW-1:0]           coef [NCOEF];
    logic signed [ACCW-1:0]  acc  [NROW];

    always_ff @(posedge clk) begin
        if (cfg_we_i && int'(cfg_addr_i) < NCOEF) coef[cfg_addr_i] <= cfg_data_i;
    end

    // One full-precision dot product per coefficient row.
    always_comb begin
        int a;
        for (int r = 0; r < NROW; r++) begin
            acc[r] = '0;
            for (int l = 0; l < NLAYERS; l++) begin
                a      = (int'(hole_i) * NROW + r) * NLAYERS + l;
                acc[r] = acc[r] + ACCW'($signed(coef[a])) * ACCW'($signed(x_i[l]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            last_o <= 1'b0;
            idx_o  <= '0;
            hole_o <= '0;
            rows_o <= '0;
        end else begin
            vld_o  <= vld_i;
            last_o <= last_i;
            idx_o  <= idx_i;
            hole_o <= hole_i;
            for (int r = 0; r < NROW; r++) rows_o[r] <= scale_q(64'(acc[r]), FRAC);
        end
    end

endmodule

// File: rtl/lfit_chi_stage.sv
module lfit_chi_stage import lfit_pkg::*; #(
    parameter int NLAYERS = 4,
    parameter int MAXCL   = 4,
    parameter int NPAR    = 2,
    parameter int NRES    = 2,
    localparam int IDXW   = $clog2(MAXCL),
    localparam int HW     = $clog2(NLAYERS + 1),
    localparam int NROW   = NPAR + NRES,
    localparam int SQW    = 2 * CW,
    localparam int CHIW   = 2 * CW + $clog2(NRES + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         vld_i,
    input  logic                         last_i,
    input  logic [NLAYERS-1:0][IDXW-1:0] idx_i,
    input  logic [HW-1:0]                hole_i,
    input  logic [NROW-1:0][CW-1:0]      rows_i,
    input  logic [CHIW-1:0]              cut_i,
    output logic                         vld_o,
    output logic                         done_o,
    output logic [NLAYERS*IDXW-1:0]      idx_o,
    output logic [HW-1:0]                hole_o,
    output logic [NPAR*CW-1:0]           par_o,
    output logic [CHIW-1:0]              chi_o
);

    logic [CHIW-1:0] chi;

    always_comb begin
        logic signed [SQW-1:0] sq;
        chi = '0;
        for (int k = 0; k < NRES; k++) begin
            sq  = SQW'($signed(rows_i[NPAR + k])) * SQW'($signed(rows_i[NPAR + k]));
            chi = chi + CHIW'($unsigned(sq));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
            hole_o <= '0;
            par_o  <= '0;
            chi_o  <= '0;
        end else begin
            vld_o  <= vld_i && (chi < cut_i);
            done_o <= last_i;
            if (vld_i) begin
                idx_o  <= idx_i;
                hole_o <= hole_i;
                par_o  <= rows_i[NPAR-1:0];
                chi_o  <= chi;
            end
        end
    end

endmodule

// File: rtl/lfit_track_fitter.sv
module lfit_track_fitter import lfit_pkg::*; #(
    parameter int NLAYERS = 4,
    parameter int MAXCL   = 4,
    parameter int NPAR    = 2,
    parameter int NRES    = 2,
    parameter int FRAC    = 8,
    parameter int IDW     = 8,
    localparam int LW     = $clog2(NLAYERS),
    localparam int IDXW   = $clog2(MAXCL),
    localparam int CNTW   = $clog2(MAXCL + 1),
    localparam int HW     = $clog2(NLAYERS + 1),
    localparam int NROW   = NPAR + NRES,
    localparam int NCOEF  = (NLAYERS + 1) * NROW * NLAYERS,
    localparam int CAW    = $clog2(NCOEF),
    localparam int CHIW   = 2 * CW + $clog2(NRES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CAW-1:0]          cfg_addr,
    input  logic [CW-1:0]           cfg_data,
    input  logic [CHIW-1:0]         chi_cut,
    input  logic                    rd_open,
    input  logic [IDW-1:0]          rd_id,
    input  logic                    hit_valid,
    input  logic [LW-1:0]           hit_layer,
    input  logic [CW-1:0]           hit_coord,
    input  logic                    rd_go,
    output logic                    busy,
    output logic                    trk_valid,
    output logic [IDW-1:0]          trk_road,
    output logic [HW-1:0]           trk_hole,
    output logic [NLAYERS*IDXW-1:0] trk_idx,
    output logic [NPAR*CW-1:0]      trk_par,
    output logic [CHIW-1:0]         trk_chi2,
    output logic                    trk_ovf,
    output logic                    rd_done
);

    logic start_w, open_w, hit_w;
    logic [NLAYERS-1:0][CNTW-1:0] cnt;
    logic [NLAYERS-1:0][CW-1:0]   x;
    logic                         e_vld, e_last, d_vld, d_last;
    logic [NLAYERS-1:0][IDXW-1:0] e_idx, d_idx;
    logic [HW-1:0]                e_hole, d_hole;
    logic [NROW-1:0][CW-1:0]      d_rows;

    assign start_w = rd_go && !busy;
    assign open_w  = rd_open && !busy;
    assign hit_w   = hit_valid && !busy && !rd_open;

    lfit_hit_store #(.NLAYERS(NLAYERS), .MAXCL(MAXCL), .IDW(IDW)) u_store (
        .clk(clk), .rst(rst),
        .open_i(open_w), .open_id_i(rd_id),
        .wr_i(hit_w), .wr_layer_i(hit_layer), .wr_coord_i(hit_coord),
        .rd_idx_i(e_idx), .rd_hole_i(e_hole),
        .cnt_o(cnt), .x_o(x), .road_o(trk_road), .ovf_o(trk_ovf)
    );

    lfit_combo_enum #(.NLAYERS(NLAYERS), .MAXCL(MAXCL)) u_enum (
        .clk(clk), .rst(rst), .start_i(start_w), .cnt_i(cnt),
        .vld_o(e_vld), .last_o(e_last), .idx_o(e_idx), .hole_o(e_hole)
    );

    lfit_dot_stage #(.NLAYERS(NLAYERS), .MAXCL(MAXCL), .NPAR(NPAR),
                     .NRES(NRES), .FRAC(FRAC)) u_dot (
        .clk(clk), .rst(rst),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .vld_i(e_vld), .last_i(e_last), .idx_i(e_idx), .hole_i(e_hole), .x_i(x),
        .vld_o(d_vld), .last_o(d_last), .idx_o(d_idx), .hole_o(d_hole), .rows_o(d_rows)
    );

    lfit_chi_stage #(.NLAYERS(NLAYERS), .MAXCL(MAXCL), .NPAR(NPAR), .NRES(NRES)) u_chi (
        .clk(clk), .rst(rst),
        .vld_i(d_vld), .last_i(d_last), .idx_i(d_idx), .hole_i(d_hole),
        .rows_i(d_rows), .cut_i(chi_cut),
        .vld_o(trk_valid), .done_o(rd_done), .idx_o(trk_idx), .hole_o(trk_hole),
        .par_o(trk_par), .chi_o(trk_chi2)
    );

    always_ff @(posedge clk) begin
        if (rst)          busy <= 1'b0;
        else if (start_w) busy <= 1'b1;
        else if (d_last)  busy <= 1'b0;
    end

endmodule

// File: rtl/lfit_track_fitter_chk.sv
module lfit_track_fitter_chk #(
    parameter int NLAYERS = 4,
    parameter int MAXCL   = 4,
    parameter int IDW     = 8,
    parameter int CHIW    = 34,
    localparam int IDXW   = $clog2(MAXCL),
    localparam int HW     = $clog2(NLAYERS + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    busy,
    input logic                    trk_valid,
    input logic [IDW-1:0]          trk_road,
    input logic [HW-1:0]           trk_hole,
    input logic [NLAYERS*IDXW-1:0] trk_idx,
    input logic [CHIW-1:0]         trk_chi2,
    input logic [CHIW-1:0]         chi_cut,
    input logic                    rd_done
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !trk_valid && !rd_done));

    assert_below_cut_R5: assert property (@(posedge clk) disable iff (rst)
        trk_valid |-> (trk_chi2 < chi_cut));

    for (genvar l = 0; l < NLAYERS; l++) begin : g_hole
        assert_hole_idx_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (trk_valid && trk_hole == HW'(l + 1)) |-> (trk_idx[l*IDXW +: IDXW] == '0));
    end

    assert_road_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(trk_road));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !busy);

    assert_record_in_road_R10: assert property (@(posedge clk) disable iff (rst)
        trk_valid |-> (busy || rd_done));

endmodule

bind lfit_track_fitter lfit_track_fitter_chk #(
    .NLAYERS(NLAYERS), .MAXCL(MAXCL), .IDW(IDW), .CHIW(CHIW)
) i_chk (.*);

// File: tb/test_lfit_track_fitter.sv
`timescale 1ns/1ps
module test_lfit_track_fitter;

    localparam int NL = 4, MC = 4, NP = 2, NR = 2, NROWS = 4, FR = 8;
    localparam longint CUTMAX = 64'h3_FFFF_FFFF;
    localparam int NT = 7;
    localparam int T_CNT [NT][NL] = '{
        '{1,1,1,1}, '{2,3,1,2}, '{4,4,4,4}, '{2,0,3,2},
        '{3,2,2,0}, '{0,0,2,2}, '{1,2,2,1}};
    localparam int T_SEED [NT] = '{3, 11, 25, 40, 57, 61, 77};
    localparam longint T_CUT [NT] = '{CUTMAX, CUTMAX, 64'd30000000, CUTMAX,
                                      64'd10000000, CUTMAX, 64'd0};
    localparam string T_TAG [NT] = '{"R3 single", "R2 uneven", "R5 full road",
                                     "R6 hole layer1", "R6 hole layer3",
                                     "R7 two empty", "R5 zero cut"};

    logic        clk = 0, rst = 1;
    logic        cfg_we = 0;
    logic [6:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic [33:0] chi_cut = '0;
    logic        rd_open = 0, hit_valid = 0, rd_go = 0;
    logic [7:0]  rd_id = '0;
    logic [1:0]  hit_layer = '0;
    logic [15:0] hit_coord = '0;
    logic        busy, trk_valid, trk_ovf, rd_done;
    logic [7:0]  trk_road;
    logic [2:0]  trk_hole;
    logic [7:0]  trk_idx;
    logic [31:0] trk_par;
    logic [33:0] trk_chi2;

    lfit_track_fitter i_lfit_track_fitter (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    int     hits_n [NL];
    int     seed_v, road_v;
    longint cut_v;
    int     e_idx [256][NL];
    longint e_par [256][NP];
    longint e_chi [256];
    int     e_hole [256];

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int cf(int s, int r, int c);
        return (((s * 37 + r * 23 + c * 11 + 5) % 61) - 30) * 8;
    endfunction

    function automatic longint cx(int seed, int l, int i);
        return longint'((((seed * 97 + l * 53 + i * 29 + 7) % 401) - 200) * 8);
    endfunction

    function automatic longint q16(longint a);
        longint v;
        v = a >>> FR;
        return longint'(shortint'(v));
    endfunction

    task automatic model_fit(input longint x [NL], input int set,
                             output longint p [NP], output longint chi);
        longint acc, q;
        chi = 0;
        for (int r = 0; r < NROWS; r++) begin
            acc = 0;
            for (int l = 0; l < NL; l++) acc += longint'(cf(set, r, l)) * x[l];
            q = q16(acc);
            if (r < NP) p[r] = q;
            else        chi += q * q;
        end
    endtask

    task automatic run_road(input string tag);
        int kept [NL];
        int lim [NL];
        int id [NL];
        longint x [NL];
        longint p [NP];
        longint chi;
        int nempty = 0, hole = 0, nexp = 0, total, rem, got = 0, cyc = 0;
        bit ovf = 0, done_seen = 0, ok;
        for (int l = 0; l < NL; l++) begin
            kept[l] = (hits_n[l] > MC) ? MC : hits_n[l];
            if (hits_n[l] > MC) ovf = 1;
            if (kept[l] == 0) begin nempty++; hole = l + 1; end
        end
        if (nempty <= 1) begin
            total = 1;
            for (int l = 0; l < NL; l++) begin
                lim[l] = (hole == l + 1) ? 1 : kept[l];
                total *= lim[l];
            end
            for (int n = 0; n < total; n++) begin
                rem = n;
                for (int l = NL - 1; l >= 0; l--) begin
                    id[l] = rem % lim[l];
                    rem   = rem / lim[l];
                    x[l]  = (hole == l + 1) ? 0 : cx(seed_v, l, id[l]);
                end
                model_fit(x, hole, p, chi);
                if (chi < cut_v) begin
                    for (int l = 0; l < NL; l++) e_idx[nexp][l] = id[l];
                    for (int j = 0; j < NP; j++) e_par[nexp][j] = p[j];
                    e_chi[nexp] = chi;
                    e_hole[nexp] = hole;
                    nexp++;
                end
            end
        end
        // drive the road
        @(negedge clk);
        rd_open = 1; rd_id = 8'(road_v);
        @(negedge clk);
        rd_open = 0;
        for (int l = 0; l < NL; l++)
            for (int i = 0; i < hits_n[l]; i++) begin
                hit_valid = 1; hit_layer = 2'(l); hit_coord = 16'(cx(seed_v, l, i));
                @(negedge clk);
            end
        hit_valid = 0;
        chi_cut = 34'(cut_v);
        rd_go = 1;
        @(negedge clk);
        rd_go = 0;
        // collect records
        while (!done_seen && cyc < 2000) begin
            if (trk_valid) begin
                if (got < nexp) begin
                    ok = (trk_road == 8'(road_v)) && (trk_ovf == ovf) &&
                         (int'(trk_hole) == e_hole[got]) &&
                         (longint'(trk_chi2) == e_chi[got]);
                    for (int l = 0; l < NL; l++)
                        if (int'(trk_idx[l*2 +: 2]) != e_idx[got][l]) ok = 0;
                    for (int j = 0; j < NP; j++)
                        if (longint'($signed(trk_par[j*16 +: 16])) != e_par[got][j]) ok = 0;
                    check(ok, $sformatf(
                        "%s R2 R3 R4 R8 R9 rec %0d: road=%0d ovf=%0d hole=%0d idx=%h par=%h chi=%0d exp road=%0d ovf=%0d hole=%0d idx=%0d%0d%0d%0d par=%0d,%0d chi=%0d",
                        tag, got, trk_road, trk_ovf, trk_hole, trk_idx, trk_par, trk_chi2,
                        road_v, ovf, e_hole[got], e_idx[got][3], e_idx[got][2],
                        e_idx[got][1], e_idx[got][0], e_par[got][0], e_par[got][1], e_chi[got]));
                end
                got++;
            end
            if (rd_done) begin
                done_seen = 1;
                check(!busy, $sformatf("%s R10 busy at done: got %0d exp 0", tag, busy));
            end
            @(negedge clk);
            cyc++;
        end
        check(done_seen, $sformatf("%s R7 R10 done seen: got %0d exp 1", tag, done_seen));
        check(!rd_done && !trk_valid, $sformatf("%s R10 after done: done=%0d valid=%0d exp 0 0",
                                                tag, rd_done, trk_valid));
        check(got == nexp, $sformatf("%s R2 R5 record count: got %0d exp %0d", tag, got, nexp));
    endtask

    initial begin
        longint x [NL];
        longint p [NP];
        longint chi;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !trk_valid && !rd_done, $sformatf(
            "R1 reset state: busy=%0d valid=%0d done=%0d exp 0 0 0", busy, trk_valid, rd_done));
        // coefficient load
        for (int s = 0; s < NL + 1; s++)
            for (int r = 0; r < NROWS; r++)
                for (int c = 0; c < NL; c++) begin
                    cfg_we = 1; cfg_addr = 7'((s * NROWS + r) * NL + c);
                    cfg_data = 16'(cf(s, r, c));
                    @(negedge clk);
                end
        cfg_we = 0;
        // table of roads
        for (int t = 0; t < NT; t++) begin
            for (int l = 0; l < NL; l++) hits_n[l] = T_CNT[t][l];
            seed_v = T_SEED[t]; cut_v = T_CUT[t]; road_v = 16 + t;
            run_road(T_TAG[t]);
        end
        // R8: overfull layer 0
        hits_n = '{6, 2, 1, 2}; seed_v = 90; cut_v = CUTMAX; road_v = 200;
        run_road("R8 overflow");
        // R5: cut boundary on a single combination
        seed_v = 123;
        for (int l = 0; l < NL; l++) x[l] = cx(seed_v, l, 0);
        model_fit(x, 0, p, chi);
        hits_n = '{1, 1, 1, 1}; cut_v = chi; road_v = 201;
        run_road("R5 cut equal");
        cut_v = chi + 1; road_v = 202;
        run_road("R5 cut above");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R10: run did not complete, got timeout exp done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule